// File: doc/BRIEF.md
# Receive-Enable Calibration Sequencer

This block trains the read receive-enable delay for the byte groups of one memory channel. Each group is watched through a pair of strobe sample bits. The groups are taken one at a time, in ascending order. For each group the sequencer drives a delay stepper held inside the block and publishes the current delay setting. It asks an outside sampler for a strobe reading and decides the next step from that reading. It first moves out of any high strobe level. It then finds the low-to-high strobe edge, moves back through the preamble, finds the edge a second time and steps back by half a clock. Once every group is done, the coarse clock count shared by all groups is split off as one common value. What is left over for each group becomes that group's own preamble offset.

A delay setting is the tuple (C, PH, T, P). C counts whole clocks, PH counts half clocks in units of 2, T counts taps and P counts sub-taps. The tap bounds depend on the speed mode. A sample request waits for a valid handshake. If the coarse count leaves its range, the run ends with an error flag.

Top module: `rcv_cal_seq`

## Requirements
- R1: After a synchronous active-low reset, `done`, `error` and `sample_req` are all 0.
- R2: After `start`, the first sample request of group 0 shows `cur_grp`=0 and `tim_c`=`cas_lat`+1, with `tim_ph`, `tim_t` and `tim_p` all 0. Every later group also begins from this setting.
- R3: While `sample_req` is 1 and `sample_vld` is 0, the published delay setting does not change. The block acts only on a reading presented together with `sample_vld`.
- R4: Let TB/PB be the tap/sub-tap bounds: 12/1 when `speed_hi`=0 and 9/8 when `speed_hi`=1. Let H=TB*PB. The setting then stands for the linear position C*2H + (PH/2)*H + T*PB + P. T stays below TB and P stays below PB. A quarter step moves (TB>>1)*PB + (TB&1)*(PB>>1) units, a full backstep moves 2H units and a half backstep moves H units.
- R5: As the first move, while either bit of `sample_hi` reads 1, the block takes a quarter step and samples again.
- R6: An edge search adds 2 to T. It then quarter-steps until either bit reads 1, takes one quarter backstep, and advances one sub-tap at a time until both bits read 1.
- R7: After the first edge search the block takes one quarter step. It then takes full backsteps while either bit reads 1, and after that runs the edge search a second time.
- R8: After the second edge search the block takes one half backstep. The resulting setting is the group's result.
- R9: With `card_f`=1, one extra tap (T+1) is added after the half backstep.
- R10: Groups are calibrated in ascending order, 0 to NGRP-1, and `cur_grp` never steps backward during a run.
- R11: At completion every `res_c` entry holds the minimum C over all groups, and each `res_pre` entry holds that group's own C minus the minimum.
- R12: If a load or step would put C below 0 or at or above 2^CW, the run stops. `done` and `error` both go to 1 and no further sample is requested.
- R13: `done` stays 1 until the next `start`, and a new run clears `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a calibration run |
| speed_hi | input | 1 | Selects tap bounds 9/8 (1) or 12/1 (0) |
| card_f | input | 1 | Add one tap to each group result |
| cas_lat | input | CW | CAS latency; the initial C is this plus one |
| sample_vld | input | 1 | Sample reading valid |
| sample_hi | input | 2 | Strobe level on the two lanes of the group |
| sample_req | output | 1 | Request a strobe sample at the published setting |
| done | output | 1 | Run finished (level) |
| error | output | 1 | Run ended on a coarse overflow |
| cur_grp | output | GW | Group being calibrated |
| tim_c | output | CW | Published whole-clock count |
| tim_ph | output | 2 | Published half-clock field |
| tim_t | output | TW | Published tap field |
| tim_p | output | PW | Published sub-tap field |
| res_c | output | NGRP*CW | Per-group common C result |
| res_pre | output | NGRP*CW | Per-group preamble offset |
| res_ph | output | NGRP*2 | Per-group half-clock result |
| res_t | output | NGRP*TW | Per-group tap result |
| res_p | output | NGRP*PW | Per-group sub-tap result |

## Verification
The sampler model in the bench answers from the published setting, so a wrong step size, a missed carry or a search phase taken out of turn changes every later reading. Such a fault therefore shows up as a different final position for that group, at the latest when `done` rises. A wrong search phase register is usually seen earlier, as a setting change during a pending request or as an edge found one clock off. A fault in the minimum logic or the group counter appears only in the result ports at completion.

// File: rtl/rcv_pkg.sv
// Shared types for the receive-enable calibration sequencer.
// Assumes: none beyond IEEE 1800-2017 enums.
package rcv_pkg;

    // Commands accepted by the delay stepper
    typedef enum logic [3:0] {
        STP_NONE  = 4'd0,
        STP_LOAD  = 4'd1,
        STP_QFWD  = 4'd2,
        STP_QBCK  = 4'd3,
        STP_FINE  = 4'd4,
        STP_FULLB = 4'd5,
        STP_HALFB = 4'd6,
        STP_T2    = 4'd7,
        STP_T1    = 4'd8
    } step_e;

    // Search phase within one group
    typedef enum logic [2:0] {
        PH_LOW  = 3'd0,
        PH_CRS1 = 3'd1,
        PH_FIN1 = 3'd2,
        PH_PRE  = 3'd3,
        PH_CRS2 = 3'd4,
        PH_FIN2 = 3'd5
    } phase_e;

    // Sequencer control state
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_INIT  = 3'd1,
        S_SAMP  = 3'd2,
        S_FIX   = 3'd3,
        S_STORE = 3'd4,
        S_FACT  = 3'd5,
        S_DONE  = 3'd6
    } state_e;

endpackage

// File: rtl/rcv_stepper.sv
// Delay stepper: holds one (C, PH, T, P) tuple and applies step commands.
// It keeps every field in range by single carry/borrow per field.
// Assumes: each step moves a field by less than its bound, so one carry
// or borrow per level is enough. A step that would push C out of range
// is refused and sets the sticky err flag; a load clears the flag when valid.
module rcv_stepper
    import rcv_pkg::*;
#(
    parameter int CW   = 4,
    parameter int TW   = 4,
    parameter int PW   = 3,
    parameter int TB_N = 12,
    parameter int PB_N = 1,
    parameter int TB_F = 9,
    parameter int PB_F = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          speed_hi,
    input  step_e         cmd,
    input  logic [CW:0]   load_c,
    output logic [CW-1:0] c_q,
    output logic [1:0]    ph_q,
    output logic [TW-1:0] t_q,
    output logic [PW-1:0] p_q,
    output logic          err
);
    localparam int CLIM = 1 << CW;

    int tb, pb;
    int dc, dph, dt, dp;
    int c_n, ph_n, t_n, p_n;
    logic bad;

    // Next tuple for the current command, with carries resolved
    always_comb begin
        tb  = speed_hi ? TB_F : TB_N;
        pb  = speed_hi ? PB_F : PB_N;
        dc  = 0;
        dph = 0;
        dt  = 0;
        dp  = 0;
        case (cmd)
            STP_QFWD:  begin dt = tb >> 1;    dp = (tb & 1) * (pb >> 1);    end
            STP_QBCK:  begin dt = -(tb >> 1); dp = -((tb & 1) * (pb >> 1)); end
            STP_FINE:  dp  = 1;
            STP_FULLB: dc  = -1;
            STP_HALFB: dph = -2;
            STP_T2:    dt  = 2;
            STP_T1:    dt  = 1;
            default:   ;
        endcase
        p_n  = int'(p_q) + dp;
        t_n  = int'(t_q) + dt;
        ph_n = int'(ph_q) + dph;
        c_n  = int'(c_q) + dc;
        if (p_n >= pb) begin
            p_n = p_n - pb;
            t_n = t_n + 1;
        end else if (p_n < 0) begin
            p_n = p_n + pb;
            t_n = t_n - 1;
        end
        if (t_n >= tb) begin
            t_n  = t_n - tb;
            ph_n = ph_n + 2;
        end else if (t_n < 0) begin
            t_n  = t_n + tb;
            ph_n = ph_n - 2;
        end
        if (ph_n >= 4) begin
            ph_n = ph_n - 4;
            c_n  = c_n + 1;
        end else if (ph_n < 0) begin
            ph_n = ph_n + 4;
            c_n  = c_n - 1;
        end
        if (cmd == STP_LOAD) begin
            c_n  = int'(load_c);
            ph_n = 0;
            t_n  = 0;
            p_n  = 0;
        end
        bad = (c_n < 0) || (c_n >= CLIM);
    end

    // Register the tuple; refuse out-of-range results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q  <= '0;
            ph_q <= '0;
            t_q  <= '0;
            p_q  <= '0;
            err  <= 1'b0;
        end else if (cmd != STP_NONE) begin
            if (bad) begin
                err <= 1'b1;
            end else begin
                c_q  <= CW'(c_n);
                ph_q <= 2'(ph_n);
                t_q  <= TW'(t_n);
                p_q  <= PW'(p_n);
                if (cmd == STP_LOAD) err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rcv_minpre.sv
// Common-coarse factoring: minimum C over all groups and each group's excess.
// Assumes: purely combinational, inputs stable when the result is used.
module rcv_minpre #(
    parameter int NG = 4,
    parameter int CW = 4
) (
    input  logic [NG-1:0][CW-1:0] c_in,
    output logic [CW-1:0]         c_min,
    output logic [NG-1:0][CW-1:0] pre
);
    // Minimum search over the groups
    always_comb begin
        c_min = c_in[0];
        for (int g = 1; g < NG; g++)
            if (c_in[g] < c_min) c_min = c_in[g];
    end

    // Per-group offset above the minimum
    genvar gi;
    generate
        for (gi = 0; gi < NG; gi++) begin : g_pre
            assign pre[gi] = c_in[gi] - c_min;
        end
    endgenerate
endmodule

// File: rtl/rcv_cal_seq.sv
// Receive-enable calibration sequencer (top).
// Walks the groups in order. For each group it runs: out-of-high search,
// edge search, quarter step plus preamble backsteps, second edge search,
// half backstep and an optional extra tap. It then factors the common C.
// Assumes: the sampler answers each request with one sample_vld pulse
// taken at the setting published while the request is high.
module rcv_cal_seq
    import rcv_pkg::*;
#(
    parameter int NGRP = 4,
    parameter int CW   = 4,
    parameter int TW   = 4,
    parameter int PW   = 3,
    parameter int TB_N = 12,
    parameter int PB_N = 1,
    parameter int TB_F = 9,
    parameter int PB_F = 8,
    localparam int GW  = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    speed_hi,
    input  logic                    card_f,
    input  logic [CW-1:0]           cas_lat,
    input  logic                    sample_vld,
    input  logic [1:0]              sample_hi,
    output logic                    sample_req,
    output logic                    done,
    output logic                    error,
    output logic [GW-1:0]           cur_grp,
    output logic [CW-1:0]           tim_c,
    output logic [1:0]              tim_ph,
    output logic [TW-1:0]           tim_t,
    output logic [PW-1:0]           tim_p,
    output logic [NGRP-1:0][CW-1:0] res_c,
    output logic [NGRP-1:0][CW-1:0] res_pre,
    output logic [NGRP-1:0][1:0]    res_ph,
    output logic [NGRP-1:0][TW-1:0] res_t,
    output logic [NGRP-1:0][PW-1:0] res_p
);
    state_e  state_q;
    phase_e  phase_q;
    logic [GW-1:0] grp_q;
    logic    err_q;
    step_e   cmd;
    logic    stp_err;
    logic    any_hi, both_hi;
    logic [CW:0] load_c;
    logic [CW-1:0] c_min;
    logic [NGRP-1:0][CW-1:0] pre_v;

    assign any_hi  = |sample_hi;
    assign both_hi = &sample_hi;
    assign load_c  = {1'b0, cas_lat} + (CW+1)'(1);

    rcv_stepper #(
        .CW(CW), .TW(TW), .PW(PW),
        .TB_N(TB_N), .PB_N(PB_N), .TB_F(TB_F), .PB_F(PB_F)
    ) i_stepper (
        .clk(clk), .rst_n(rst_n), .speed_hi(speed_hi), .cmd(cmd),
        .load_c(load_c), .c_q(tim_c), .ph_q(tim_ph), .t_q(tim_t),
        .p_q(tim_p), .err(stp_err)
    );

    rcv_minpre #(.NG(NGRP), .CW(CW)) i_minpre (
        .c_in(res_c), .c_min(c_min), .pre(pre_v)
    );

    // Step command chosen from state, phase and the current reading
    always_comb begin
        cmd = STP_NONE;
        case (state_q)
            S_INIT: cmd = STP_LOAD;
            S_SAMP: if (sample_vld && !stp_err) begin
                case (phase_q)
                    PH_LOW:  cmd = any_hi  ? STP_QFWD  : STP_T2;
                    PH_CRS1,
                    PH_CRS2: cmd = any_hi  ? STP_QBCK  : STP_QFWD;
                    PH_FIN1: cmd = both_hi ? STP_QFWD  : STP_FINE;
                    PH_PRE:  cmd = any_hi  ? STP_FULLB : STP_T2;
                    PH_FIN2: cmd = both_hi ? STP_HALFB : STP_FINE;
                    default: cmd = STP_NONE;
                endcase
            end
            S_FIX:  cmd = card_f ? STP_T1 : STP_NONE;
            default: ;
        endcase
    end

    // Control state, search phase, group counter and result storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            phase_q <= PH_LOW;
            grp_q   <= '0;
            err_q   <= 1'b0;
            res_c   <= '0;
            res_pre <= '0;
            res_ph  <= '0;
            res_t   <= '0;
            res_p   <= '0;
        end else begin
            case (state_q)
                S_IDLE, S_DONE: if (start) begin
                    state_q <= S_INIT;
                    grp_q   <= '0;
                    err_q   <= 1'b0;
                    res_pre <= '0;
                end
                S_INIT: begin
                    state_q <= S_SAMP;
                    phase_q <= PH_LOW;
                end
                S_SAMP: if (stp_err) begin
                    state_q <= S_DONE;
                    err_q   <= 1'b1;
                end else if (sample_vld) begin
                    case (phase_q)
                        PH_LOW:  if (!any_hi)  phase_q <= PH_CRS1;
                        PH_CRS1: if (any_hi)   phase_q <= PH_FIN1;
                        PH_FIN1: if (both_hi)  phase_q <= PH_PRE;
                        PH_PRE:  if (!any_hi)  phase_q <= PH_CRS2;
                        PH_CRS2: if (any_hi)   phase_q <= PH_FIN2;
                        PH_FIN2: if (both_hi)  state_q <= S_FIX;
                        default: phase_q <= PH_LOW;
                    endcase
                end
                S_FIX: state_q <= S_STORE;
                S_STORE: if (stp_err) begin
                    state_q <= S_DONE;
                    err_q   <= 1'b1;
                end else begin
                    res_c[grp_q]  <= tim_c;
                    res_ph[grp_q] <= tim_ph;
                    res_t[grp_q]  <= tim_t;
                    res_p[grp_q]  <= tim_p;
                    if (grp_q == GW'(NGRP - 1)) begin
                        state_q <= S_FACT;
                    end else begin
                        grp_q   <= grp_q + GW'(1);
                        state_q <= S_INIT;
                    end
                end
                S_FACT: begin
                    for (int g = 0; g < NGRP; g++) res_c[g] <= c_min;
                    res_pre <= pre_v;
                    state_q <= S_DONE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign sample_req = (state_q == S_SAMP) && !stp_err;
    assign done       = (state_q == S_DONE);
    assign error      = err_q;
    assign cur_grp    = grp_q;
endmodule

// File: rtl/rcv_cal_chk.sv
// Property checker for rcv_cal_seq, bound to every instance.
// Assumes: the ports named below exist on the top with matching widths.
module rcv_cal_chk #(
    parameter int NGRP = 4,
    parameter int CW   = 4,
    parameter int TW   = 4,
    parameter int PW   = 3,
    parameter int TB_N = 12,
    parameter int PB_N = 1,
    parameter int TB_F = 9,
    parameter int PB_F = 8,
    localparam int GW  = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    speed_hi,
    input logic                    sample_vld,
    input logic                    sample_req,
    input logic                    done,
    input logic                    error,
    input logic [GW-1:0]           cur_grp,
    input logic [CW-1:0]           tim_c,
    input logic [1:0]              tim_ph,
    input logic [TW-1:0]           tim_t,
    input logic [PW-1:0]           tim_p,
    input logic [NGRP-1:0][CW-1:0] res_c,
    input logic [NGRP-1:0][CW-1:0] res_pre
);
    logic all_eq, some_zero, in_range;

    // Summaries of the result vectors and the tap range
    always_comb begin
        all_eq    = 1'b1;
        some_zero = 1'b0;
        for (int g = 0; g < NGRP; g++) begin
            if (res_c[g] != res_c[0]) all_eq = 1'b0;
            if (res_pre[g] == '0)     some_zero = 1'b1;
        end
        in_range = speed_hi ? (int'(tim_t) < TB_F && int'(tim_p) < PB_F)
                            : (int'(tim_t) < TB_N && int'(tim_p) < PB_N);
    end

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done); // R12
    AST_NO_REQ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sample_req); // R13
    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_req && !sample_vld) |=>
            ($stable(tim_c) && $stable(tim_ph) && $stable(tim_t) && $stable(tim_p))); // R3
    AST_TAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req |-> in_range); // R4
    AST_GRP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_grp) |-> (cur_grp == $past(cur_grp) + GW'(1) || cur_grp == '0)); // R10
    AST_COMMON_C: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error && $past(!done)) |-> (all_eq && some_zero)); // R11
endmodule

bind rcv_cal_seq rcv_cal_chk #(
    .NGRP(NGRP), .CW(CW), .TW(TW), .PW(PW),
    .TB_N(TB_N), .PB_N(PB_N), .TB_F(TB_F), .PB_F(PB_F)
) i_rcv_cal_chk (.*);

// File: tb/test_rcv_cal_seq.sv
// Directed bench for rcv_cal_seq: a strobe model answers sample requests,
// and a linear-position reference of the search predicts each group result.
module test_rcv_cal_seq;
    localparam int NG = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic speed_hi = 1'b0;
    logic card_f = 1'b0;
    logic [3:0] cas_lat = 4'd5;
    logic sample_vld = 1'b0;
    logic [1:0] sample_hi = 2'b00;
    logic sample_req, done, error;
    logic [1:0] cur_grp;
    logic [3:0] tim_c, tim_t;
    logic [1:0] tim_ph;
    logic [2:0] tim_p;
    logic [NG-1:0][3:0] res_c, res_pre, res_t;
    logic [NG-1:0][1:0] res_ph;
    logic [NG-1:0][2:0] res_p;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int HH = 12, PB = 1, TB = 12, QS = 6;
    int s0 [NG];
    int s1 [NG];
    int lat_cfg = 1;
    int cas_cur = 5;
    bit first_req = 0;
    bit grp_bad = 0;
    int last_grp = 0;

    rcv_cal_seq i_rcv_cal_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .speed_hi(speed_hi),
        .card_f(card_f), .cas_lat(cas_lat), .sample_vld(sample_vld),
        .sample_hi(sample_hi), .sample_req(sample_req), .done(done),
        .error(error), .cur_grp(cur_grp), .tim_c(tim_c), .tim_ph(tim_ph),
        .tim_t(tim_t), .tim_p(tim_p), .res_c(res_c), .res_pre(res_pre),
        .res_ph(res_ph), .res_t(res_t), .res_p(res_p)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int pos_of(int c, int ph, int t, int p);
        return c * 2 * HH + (ph / 2) * HH + t * PB + p;
    endfunction

    function automatic bit lane_hi(int pos, int s);
        return (pos >= s) && (((pos - s) % (2 * HH)) < HH);
    endfunction

    task automatic mv(inout int pos, inout bit ov, input int d);
        if (!ov) begin
            pos = pos + d;
            if (pos < 0 || pos >= 32 * HH) ov = 1;
        end
    endtask

    task automatic edge_srch(input int g, inout int pos, inout bit ov);
        mv(pos, ov, 2 * PB);
        while (!ov && !(lane_hi(pos, s0[g]) || lane_hi(pos, s1[g]))) mv(pos, ov, QS);
        mv(pos, ov, -QS);
        while (!ov && !(lane_hi(pos, s0[g]) && lane_hi(pos, s1[g]))) mv(pos, ov, 1);
    endtask

    // Reference search on the linear position (R5..R9)
    task automatic ref_grp(input int g, input bit cf, input int pos0,
                           output int pos, output bit ov);
        pos = pos0;
        ov = (pos0 >= 32 * HH);
        while (!ov && (lane_hi(pos, s0[g]) || lane_hi(pos, s1[g]))) mv(pos, ov, QS);
        edge_srch(g, pos, ov);
        mv(pos, ov, QS);
        while (!ov && (lane_hi(pos, s0[g]) || lane_hi(pos, s1[g]))) mv(pos, ov, -2 * HH);
        edge_srch(g, pos, ov);
        mv(pos, ov, -HH);
        if (cf) mv(pos, ov, PB);
    endtask

    // Strobe sampler: answers each request after lat_cfg cycles (R2, R3, R10)
    initial begin
        bit waiting = 0;
        int cnt = 0;
        int snap = 0;
        forever begin
            @(negedge clk);
            sample_vld = 1'b0;
            if (sample_req) begin
                if (first_req) begin
                    check(tim_c == 4'(cas_cur + 1) && tim_ph == 0 && tim_t == 0 &&
                          tim_p == 0 && cur_grp == 0, "R2", "initial setting c",
                          int'(tim_c), cas_cur + 1);
                    first_req = 0;
                end
                if (int'(cur_grp) < last_grp) grp_bad = 1;
                last_grp = int'(cur_grp);
                if (!waiting) begin
                    waiting = 1;
                    cnt = lat_cfg;
                    snap = pos_of(tim_c, tim_ph, tim_t, tim_p);
                end
                if (cnt == 0) begin
                    if (pos_of(tim_c, tim_ph, tim_t, tim_p) != snap)
                        check(0, "R3", "setting moved while pending",
                              pos_of(tim_c, tim_ph, tim_t, tim_p), snap);
                    sample_hi = {lane_hi(snap, s1[cur_grp]), lane_hi(snap, s0[cur_grp])};
                    sample_vld = 1'b1;
                    waiting = 0;
                end else begin
                    cnt--;
                end
            end
        end
    end

    task automatic run_case(input string tag, input bit spd, input bit cf,
                            input int cas, input int lat, input bit exp_err);
        int fpos [NG];
        bit ov_any;
        int cmin, n;
        int ec [NG];
        TB = spd ? 9 : 12;
        PB = spd ? 8 : 1;
        HH = TB * PB;
        QS = (TB >> 1) * PB + (TB & 1) * (PB >> 1);
        ov_any = 0;
        cmin = 99;
        for (int g = 0; g < NG; g++) begin
            bit ov;
            ref_grp(g, cf, (cas + 1) * 2 * HH, fpos[g], ov);
            if (ov) ov_any = 1;
            ec[g] = fpos[g] / (2 * HH);
            if (ec[g] < cmin) cmin = ec[g];
        end
        check(ov_any == exp_err, tag, "reference overflow expectation", ov_any, exp_err);
        @(negedge clk);
        speed_hi = spd; card_f = cf; cas_lat = 4'(cas); cas_cur = cas;
        lat_cfg = lat; first_req = 1; grp_bad = 0; last_grp = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 40000) begin @(negedge clk); n++; end
        check(done == 1'b1, "R13", {tag, " done reached"}, done, 1);
        check(error == exp_err, "R12", {tag, " error flag"}, error, exp_err);
        check(!sample_req, "R12", {tag, " no request at done"}, sample_req, 0);
        if (!exp_err) begin
            check(!grp_bad && last_grp == NG - 1, "R10", {tag, " group order"},
                  last_grp, NG - 1);
            for (int g = 0; g < NG; g++) begin
                int r, eph, et, ep;
                r = fpos[g] % (2 * HH);
                eph = 2 * (r / HH);
                et = (r % HH) / PB;
                ep = r % PB;
                check(res_ph[g] == 2'(eph) && res_t[g] == 4'(et) && res_p[g] == 3'(ep),
                      tag, $sformatf("group %0d fine position", g),
                      int'(res_ph[g]) * 1000 + int'(res_t[g]) * 10 + int'(res_p[g]),
                      eph * 1000 + et * 10 + ep);
                check(res_c[g] == 4'(cmin) && res_pre[g] == 4'(ec[g] - cmin), "R11",
                      $sformatf("%s group %0d c/pre", tag, g),
                      int'(res_c[g]) * 100 + int'(res_pre[g]), cmin * 100 + ec[g] - cmin);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                check(0, "R13", "watchdog expired", cyc, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!done && !error && !sample_req, "R1", "outputs in reset",
              {done, error, sample_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !error && !sample_req, "R1", "outputs after reset",
              {done, error, sample_req}, 0);
    endtask

    task automatic t_base;    // R6 R7 R8, skewed lanes in group 1
        s0 = '{150, 160, 170, 200}; s1 = '{150, 163, 170, 200};
        run_case("R8", 0, 0, 5, 1, 0);
    endtask

    task automatic t_fast;    // R4 tap bounds 9/8
        s0 = '{900, 950, 1000, 1100}; s1 = '{900, 960, 1000, 1130};
        run_case("R4", 1, 0, 5, 0, 0);
    endtask

    task automatic t_cardf;   // R9 extra tap
        s0 = '{130, 135, 150, 170}; s1 = '{130, 140, 150, 170};
        run_case("R9", 0, 1, 4, 2, 0);
    endtask

    task automatic t_inhigh;  // R5 start inside a high level, R7 preamble walk-back
        s0 = '{140, 135, 100, 144}; s1 = '{140, 135, 100, 150};
        run_case("R5", 0, 0, 5, 1, 0);
    endtask

    task automatic t_ovf;     // R12 load and mid-search overflow
        s0 = '{150, 150, 150, 150}; s1 = '{150, 150, 150, 150};
        run_case("R12", 0, 0, 15, 1, 1);
        s0 = '{500, 500, 500, 500}; s1 = '{500, 500, 500, 500};
        run_case("R12", 0, 0, 14, 0, 1);
    endtask

    task automatic t_restart; // R13 new run after an error, R6 lane skew
        s0 = '{150, 158, 166, 180}; s1 = '{155, 158, 170, 180};
        run_case("R6", 0, 0, 5, 3, 0);
    endtask

    initial begin
        t_reset();
        t_base();
        t_fast();
        t_cardf();
        t_inhigh();
        t_ovf();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule